// File: doc/BRIEF.md
# Four-Channel Dual-Resolution LED PWM Driver

This block drives four LED pins. Each pin has an 8-bit duty register and a 2-bit output mode. One mode gives a 256-step PWM whose period is 256 step ticks. Another reads only the top six bits of the same duty register and gives a 64-step PWM that repeats every 64 ticks, which is four times as fast. The two remaining codes hold the pin fully off or fully on. An external bus controller supplies the register writes and one-cycle pulses for end-of-transaction (`bus_stop`) and byte acknowledge (`bus_ack`). A free-running step tick, nominally 400 kHz, paces both PWM schemes.

Duty and mode writes land in shadow registers. A configuration bit picks which bus event arms a transfer to the active registers: a stop, or each acknowledge. The transfer itself waits for the next 256-tick period boundary, so several drivers that see the same stop switch together and no runt pulse is produced. The configuration register takes effect at once. It holds the output inversion bit and the pin drive style, which is either open-drain or push-pull.

The write port uses a valid/ready pair. `wr_ready` is held high, so the port never applies back-pressure. A write is accepted on every clock edge where `wr_valid` is high.

Top module: `led_pwm4`

## Requirements
- R1: After reset, `led_out` is 0000 and `led_oe` is 1111: all modes are 00, all duties are 00h, inversion is off and the drive style is push-pull.
- R2: With mode code 10, channel n is high for exactly D of every 256 ticks, where D is its duty register (8 bits, at address 02h+n).
- R3: With mode code 11, channel n is high for 4·D[7:2] of every 256 ticks, and duty bits [1:0] have no effect.
- R4: Mode code 00 holds the output low and code 01 holds it high. The mode register is at 08h, and channel n uses bits [2n+1:2n].
- R5: Bit 0 of the configuration register (address 01h) inverts all four outputs, and the change is seen on `led_out` two clock edges after the write.
- R6: When configuration bit 1 is 0, shadow duty and mode values reach the outputs only after a `bus_stop` pulse followed by a period boundary, and `bus_ack` has no effect.
- R7: When configuration bit 1 is 1, shadow values reach the outputs after a `bus_ack` pulse followed by a period boundary, and `bus_stop` has no effect.
- R8: Active duty and mode values change only on a tick that wraps the 8-bit step counter. While `step_tick` is low, an armed update stays pending.
- R9: When configuration bit 2 is 0 (open-drain), `led_oe[n]` equals the inverse of `led_out[n]`. When it is 1 (push-pull), `led_oe` is all ones.
- R10: `wr_ready` is always 1, and writes to addresses other than 01h to 05h and 08h have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_tick | input | 1 | One-cycle PWM step pulse |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accept, always high |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| bus_stop | input | 1 | End-of-transaction pulse |
| bus_ack | input | 1 | Byte acknowledge pulse |
| led_out | output | 4 | LED logic level per channel |
| led_oe | output | 4 | Pin drive enable per channel |

## Verification
The assertions take for granted that `step_tick`, `bus_stop` and `bus_ack` are synchronous to `clk` and free of X once reset is released. They also take for granted that each event pulse lasts a single cycle, so one stop or acknowledge arms exactly one transfer. The stimulus drives every input at the falling edge and raises each event for exactly one cycle. It holds `step_tick` low only in the scenario that checks an armed update is held back, and keeps it high at every other time so that counting high cycles over any 256-cycle window measures the duty exactly.

// File: rtl/led_pwm_pkg.sv
package led_pwm_pkg;
  localparam int NCH    = 4;
  localparam int DUTY_W = 8;
  localparam int GRP_W  = 6;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] CFG_ADDR   = 4'h1;
  localparam logic [ADDR_W-1:0] DUTY_BASE  = 4'h2;
  localparam logic [ADDR_W-1:0] MODE_ADDR  = 4'h8;

  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_ON  = 2'b01,
    MODE_IND = 2'b10,
    MODE_GRP = 2'b11
  } chan_mode_e;
endpackage

// File: rtl/led_pwm_timebase.sv
module led_pwm_timebase #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_tick,
  output logic [CNT_W-1:0] cnt,
  output logic             boundary
);
  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (step_tick) cnt <= cnt + 1'b1;
  end

  assign boundary = step_tick && (cnt == {CNT_W{1'b1}});
endmodule

// File: rtl/led_pwm_regs.sv
module led_pwm_regs
  import led_pwm_pkg::*;
#(
  parameter int N  = NCH,
  parameter int DW = DUTY_W,
  parameter int AW = ADDR_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [DW-1:0]         wr_data,
  input  logic                  bus_stop,
  input  logic                  bus_ack,
  input  logic                  boundary,
  output logic                  cfg_inv,
  output logic                  cfg_on_ack,
  output logic                  cfg_totem,
  output logic [N-1:0][DW-1:0]  act_duty,
  output logic [N-1:0][1:0]     act_mode,
  output logic                  armed
);
  localparam int MODE_BITS = 2 * N;

  logic [N-1:0][DW-1:0] sh_duty;
  logic [N-1:0][1:0]    sh_mode;
  logic                 event_hit;
  logic                 do_copy;

  assign event_hit = cfg_on_ack ? bus_ack : bus_stop;
  assign do_copy   = boundary && (armed || event_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_inv    <= 1'b0;
      cfg_on_ack <= 1'b0;
      cfg_totem  <= 1'b1;
    end else if (wr_en && wr_addr == CFG_ADDR) begin
      cfg_inv    <= wr_data[0];
      cfg_on_ack <= wr_data[1];
      cfg_totem  <= wr_data[2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sh_mode <= '0;
    else if (wr_en && wr_addr == MODE_ADDR) sh_mode <= wr_data[MODE_BITS-1:0];
  end

  for (genvar i = 0; i < N; i++) begin : g_duty
    always_ff @(posedge clk) begin
      if (!rst_n) sh_duty[i] <= '0;
      else if (wr_en && wr_addr == AW'(DUTY_BASE + i)) sh_duty[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      act_duty <= '0;
      act_mode <= '0;
    end else begin
      if (do_copy) begin
        act_duty <= sh_duty;
        act_mode <= sh_mode;
        armed    <= 1'b0;
      end else if (event_hit) begin
        armed    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/led_pwm_slice.sv
module led_pwm_slice
  import led_pwm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DW    = DUTY_W,
  parameter int GW    = GRP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [DW-1:0]    duty,
  input  logic [1:0]       mode,
  input  logic             inv,
  input  logic             totem,
  output logic             pin_out,
  output logic             pin_oe
);
  logic lit;
  logic lvl;

  always_comb begin
    unique case (chan_mode_e'(mode))
      MODE_OFF: lit = 1'b0;
      MODE_ON:  lit = 1'b1;
      MODE_IND: lit = cnt[DW-1:0] < duty;
      MODE_GRP: lit = cnt[GW-1:0] < duty[DW-1:DW-GW];
      default:  lit = 1'b0;
    endcase
  end

  assign lvl = lit ^ inv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_out <= 1'b0;
      pin_oe  <= 1'b1;
    end else begin
      pin_out <= lvl;
      pin_oe  <= totem || !lvl;
    end
  end
endmodule

// File: rtl/led_pwm4.sv
module led_pwm4
  import led_pwm_pkg::*;
#(
  parameter int N  = NCH,
  parameter int DW = DUTY_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_tick,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          bus_stop,
  input  logic          bus_ack,
  output logic [N-1:0]  led_out,
  output logic [N-1:0]  led_oe
);
  localparam int CNT_W = DW;

  logic [CNT_W-1:0]     cnt;
  logic                 boundary;
  logic                 cfg_inv, cfg_on_ack, cfg_totem, armed;
  logic [N-1:0][DW-1:0] act_duty;
  logic [N-1:0][1:0]    act_mode;

  assign wr_ready = 1'b1;

  led_pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .step_tick(step_tick),
    .cnt(cnt), .boundary(boundary)
  );

  led_pwm_regs #(.N(N), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_valid && wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .bus_stop(bus_stop), .bus_ack(bus_ack), .boundary(boundary),
    .cfg_inv(cfg_inv), .cfg_on_ack(cfg_on_ack), .cfg_totem(cfg_totem),
    .act_duty(act_duty), .act_mode(act_mode), .armed(armed)
  );

  for (genvar i = 0; i < N; i++) begin : g_ch
    led_pwm_slice #(.CNT_W(CNT_W), .DW(DW), .GW(GRP_W)) u_slice (
      .clk(clk), .rst_n(rst_n), .cnt(cnt),
      .duty(act_duty[i]), .mode(act_mode[i]),
      .inv(cfg_inv), .totem(cfg_totem),
      .pin_out(led_out[i]), .pin_oe(led_oe[i])
    );
  end
endmodule

// File: rtl/led_pwm4_chk.sv
module led_pwm4_chk #(
  parameter int N  = 4,
  parameter int DW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_tick,
  input logic              bus_stop,
  input logic              bus_ack,
  input logic [DW-1:0]     cnt,
  input logic              cfg_inv,
  input logic              cfg_on_ack,
  input logic              cfg_totem,
  input logic              armed,
  input logic [N*DW-1:0]   act_duty,
  input logic [2*N-1:0]    act_mode,
  input logic [N-1:0]      led_out,
  input logic [N-1:0]      led_oe
);
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_tick |=> cnt == $past(cnt) + 1'b1);

  // R8
  hold_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_tick && cnt == {DW{1'b1}}) |=> ($stable(act_duty) && $stable(act_mode)));

  // R6
  arm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> ($past(cfg_on_ack) ? $past(bus_ack) : $past(bus_stop)));

  // R9
  totem_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_totem) |-> led_oe == {N{1'b1}});

  // R9
  open_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_totem) |-> led_oe == ~led_out);

  for (genvar i = 0; i < N; i++) begin : g_fix
    // R4
    forced_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_mode[2*i +: 2] == 2'b01 |=> led_out[i] == !$past(cfg_inv));
    // R4
    forced_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_mode[2*i +: 2] == 2'b00 |=> led_out[i] == $past(cfg_inv));
  end
endmodule

bind led_pwm4 led_pwm4_chk #(.N(N), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_tick(step_tick),
  .bus_stop(bus_stop), .bus_ack(bus_ack), .cnt(cnt),
  .cfg_inv(cfg_inv), .cfg_on_ack(cfg_on_ack), .cfg_totem(cfg_totem),
  .armed(armed), .act_duty(act_duty), .act_mode(act_mode),
  .led_out(led_out), .led_oe(led_oe)
);

// File: tb/led_pwm4_bench.sv
module led_pwm4_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_tick = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       bus_stop = 1'b0;
  logic       bus_ack = 1'b0;
  logic [3:0] led_out;
  logic [3:0] led_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  led_pwm4 u_led_pwm4 (
    .clk(clk), .rst_n(rst_n), .step_tick(step_tick),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .bus_stop(bus_stop), .bus_ack(bus_ack),
    .led_out(led_out), .led_oe(led_oe)
  );

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      finish_run();
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); bus_stop = 1'b1;
    @(negedge clk); bus_stop = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); bus_ack = 1'b1;
    @(negedge clk); bus_ack = 1'b0;
  endtask

  task automatic measure(int ch, output int hi);
    hi = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (led_out[ch]) hi++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 led_out", int'(led_out), 0);
    chk("R1 led_oe", int'(led_oe), 15);
    chk("R10 wr_ready", int'(wr_ready), 1);
  endtask

  task automatic t_individual();
    int hi;
    wr(4'h2, 8'h00); wr(4'h3, 8'h40); wr(4'h4, 8'hFF); wr(4'h5, 8'h80);
    wr(4'h8, 8'hAA);
    pulse_stop();
    wait_cyc(600);
    measure(0, hi); chk("R2 ch0 duty 00h", hi, 0);
    measure(1, hi); chk("R2 ch1 duty 40h", hi, 64);
    measure(2, hi); chk("R2 ch2 duty FFh", hi, 255);
    measure(3, hi); chk("R2 ch3 duty 80h", hi, 128);
  endtask

  task automatic t_group();
    int hi;
    wr(4'h2, 8'hFF); wr(4'h3, 8'h83); wr(4'h4, 8'h03); wr(4'h5, 8'h3C);
    wr(4'h8, 8'hFF);
    pulse_stop();
    wait_cyc(600);
    measure(0, hi); chk("R3 ch0 duty FFh", hi, 252);
    measure(1, hi); chk("R3 ch1 duty 83h low bits ignored", hi, 128);
    measure(2, hi); chk("R3 ch2 duty 03h low bits ignored", hi, 0);
    measure(3, hi); chk("R3 ch3 duty 3Ch", hi, 60);
  endtask

  task automatic t_fixed();
    wr(4'h8, 8'h44);
    pulse_stop();
    wait_cyc(600);
    chk("R4 fixed off/on", int'(led_out), 4'b1010);
    wait_cyc(100);
    chk("R4 fixed levels steady", int'(led_out), 4'b1010);
  endtask

  task automatic t_invert();
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 4'h1; wr_data = 8'h05;
    @(negedge clk);
    wr_valid = 1'b0;
    @(negedge clk);
    chk("R5 inverted after two edges", int'(led_out), 4'b0101);
    wr(4'h1, 8'h04);
    wait_cyc(2);
    chk("R5 inversion cleared", int'(led_out), 4'b1010);
  endtask

  task automatic t_stop_mode();
    wr(4'h8, 8'h11);
    pulse_ack();
    wait_cyc(600);
    chk("R6 ack ignored in stop mode", int'(led_out), 4'b1010);
    pulse_stop();
    wait_cyc(600);
    chk("R6 applied after stop", int'(led_out), 4'b0101);
  endtask

  task automatic t_ack_mode();
    wr(4'h1, 8'h06);
    wr(4'h8, 8'h44);
    pulse_stop();
    wait_cyc(600);
    chk("R7 stop ignored in ack mode", int'(led_out), 4'b0101);
    pulse_ack();
    wait_cyc(600);
    chk("R7 applied after ack", int'(led_out), 4'b1010);
    wr(4'h1, 8'h04);
  endtask

  task automatic t_boundary();
    @(negedge clk); step_tick = 1'b0;
    wr(4'h8, 8'h11);
    pulse_stop();
    wait_cyc(50);
    chk("R8 held without boundary", int'(led_out), 4'b1010);
    @(negedge clk); step_tick = 1'b1;
    wait_cyc(600);
    chk("R8 applied at boundary", int'(led_out), 4'b0101);
  endtask

  task automatic t_open_drain();
    wr(4'h1, 8'h00);
    wait_cyc(2);
    chk("R9 open-drain oe", int'(led_oe), 4'b1010);
    wr(4'h8, 8'h44);
    pulse_stop();
    wait_cyc(600);
    chk("R9 open-drain out", int'(led_out), 4'b1010);
    chk("R9 open-drain oe follows", int'(led_oe), 4'b0101);
  endtask

  task automatic t_unmapped();
    wr(4'h6, 8'hFF); wr(4'h0, 8'hFF); wr(4'h9, 8'hFF); wr(4'hF, 8'h55);
    pulse_stop();
    wait_cyc(600);
    chk("R10 unmapped out unchanged", int'(led_out), 4'b1010);
    chk("R10 unmapped oe unchanged", int'(led_oe), 4'b0101);
    chk("R10 wr_ready high", int'(wr_ready), 1);
  endtask

  initial begin
    wait_cyc(3);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    @(negedge clk); step_tick = 1'b1;
    t_individual();
    t_group();
    t_fixed();
    t_invert();
    t_stop_mode();
    t_ack_mode();
    t_boundary();
    t_open_drain();
    t_unmapped();
    finish_run();
  end
endmodule